// File: doc/BRIEF.md
# Single-Wire Parity Chunk Engine

This block moves one chunk of 1 to `MAX_BITS` data bits over a single shared line. It does not drive the line itself. It produces a drive enable and a drive value for an open-drain style pad, and it reads back the pad level. The pad level is high when nothing drives it, because of a pull-up. The bit period is `BIT_CYC` clock cycles. At the 200 MHz bench clock, the 6 us default period is 1200 cycles. Other useful settings are 4, 12, 24, 36 and 48 us.

**Transmit.** A transmitted chunk is framed as follows:
- A sync pulse: the line is held low for one period, then released high for one cycle.
- The data bits, most significant first, one period each.
- One even-parity bit.
- After the parity bit the line is parked low, so that the next sync pulse starts with a rising edge.

**Receive.** A receive works in two bounded waits and then samples:
- It waits a bounded time for the line to go low.
- It then waits for the line to come back high. That rising edge is the timing reference.
- It samples every data bit and the parity bit half a period into its window.
- It reports the data, a parity-error flag, or a timeout when the edge never comes.

A higher-level sequencer drives the block through a start/ready/done handshake. That sequencer handles transactions, turnaround and buffers.

Top module: `swl_link`

## Requirements
- R1: `ready_o` is high exactly when the engine is idle. A `start_i` seen while `ready_o` is high is accepted, and `ready_o` is low from the next cycle until the chunk ends. `done_o` is a one-cycle pulse in the first idle cycle after a chunk. A `start_i` while busy is ignored, and so are the data, count and direction presented with it.
- R2: `nbits_i` selects 1 to `MAX_BITS` data bits. A value of 0, or any value above `MAX_BITS`, selects `MAX_BITS`.
- R3: A transmit (`dir_tx_i`=1) drives the line low for `BIT_CYC` cycles. This starts in the cycle after acceptance. The line is then driven high for exactly one cycle.
- R4: Transmit data follows the sync pulse directly, starting with `tx_data_i[n-1]` and ending with `tx_data_i[0]`, where n is the selected count. Each bit is driven for `BIT_CYC` cycles.
- R5: The data is followed by one `BIT_CYC`-cycle parity bit equal to the XOR of the n data bits (even parity). After that the line is driven low (`line_oe_o`=1, `line_do_o`=0), and `done_o` rises in the same cycle. The line stays driven low while idle until a receive is accepted.
- R6: From the cycle after a receive (`dir_tx_i`=0) is accepted, `line_oe_o` is 0. Whenever `line_oe_o` is 0, `line_do_o` is 0.
- R7: A receive first waits up to `WAIT_PERIODS*BIT_CYC` cycles for `line_i` low. If the line stays high through that window, the first cycle after the window becomes the timing reference.
- R8: The reference cycle E is the first cycle at which `line_i` is high after the low wait. Bit k (data bits, then parity at k=n) is sampled in cycle E+1+k*`BIT_CYC`+floor(`BIT_CYC`/2). Line values in all other cycles of the bit windows have no effect.
- R9: The received bits appear right-aligned in `rx_data_o`, first received bit at position n-1, with the upper bits zero. `done_o` rises in cycle E+1+(n+1)*`BIT_CYC`.
- R10: `par_err_o` is 1 when the sampled parity bit differs from the XOR of the sampled data bits.
- R11: If `line_i` stays low for `WAIT_PERIODS*BIT_CYC` cycles while the engine waits for the rising edge, the receive ends. At that point `done_o` pulses, `timeout_o` is 1, and both `par_err_o` and `rx_data_o` are 0.
- R12: `rx_data_o`, `par_err_o` and `timeout_o` are cleared when any chunk is accepted. They are held unchanged while the engine is idle.
- R13: After reset the outputs are as follows. `ready_o` is 1. `done_o`, `line_oe_o`, `line_do_o`, `rx_data_o`, `par_err_o` and `timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a chunk |
| dir_tx_i | input | 1 | 1 = transmit, 0 = receive |
| nbits_i | input | $clog2(MAX_BITS+1) | Data bit count (0 or above MAX_BITS means MAX_BITS) |
| tx_data_i | input | MAX_BITS | Data to send, right-aligned |
| ready_o | output | 1 | Engine idle, request can be accepted |
| done_o | output | 1 | One-cycle pulse at chunk end |
| rx_data_o | output | MAX_BITS | Received data, right-aligned |
| par_err_o | output | 1 | Received parity mismatch |
| timeout_o | output | 1 | Receive gave up waiting for the rising edge |
| line_i | input | 1 | Sampled line level (pulled high) |
| line_oe_o | output | 1 | Line drive enable |
| line_do_o | output | 1 | Line drive value |

## Verification
The bound assertions check the following on every cycle:
- the handshake: busy after acceptance, and done only as a one-cycle pulse while idle;
- that the line level is zero whenever the drive is released;
- that a transmit always opens with the line driven low;
- that a receive always releases the line;
- that results are stable while idle;
- that a timeout never reports parity or data.

Only the bench's scenarios can show frame timing and content: the exact sync-pulse width, MSB-first order, the parity value, mid-window sampling with glitches on window edges, count clamping, the expired low wait, and the cycle at which a timeout completes. The bench does this with a reference built from cycle offsets, compared on every clock.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC_LO,
    ST_SYNC_HI,
    ST_TX_BIT,
    ST_RX_LO,
    ST_RX_HI,
    ST_RX_BIT
  } swl_state_e;
endpackage

// File: rtl/swl_period_cnt.sv
// Wrapping period counter: mid_o at MID, last_o at PERIOD-1
module swl_period_cnt #(
  parameter int PERIOD = 8,
  parameter int MID    = PERIOD / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic mid_o,
  output logic last_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(PERIOD - 1));
  assign mid_o  = (cnt_q == CW'(MID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/swl_shift_par.sv
// Shared left-shift register with running parity
module swl_shift_par #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         shift_in_i,
  input  logic         par_bit_i,
  output logic [W-1:0] sreg_o,
  output logic         par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_o <= '0;
      par_o  <= 1'b0;
    end else if (load_i) begin
      sreg_o <= load_val_i;
      par_o  <= 1'b0;
    end else if (shift_i) begin
      sreg_o <= {sreg_o[W-2:0], shift_in_i};
      par_o  <= par_o ^ par_bit_i;
    end
  end
endmodule

// File: rtl/swl_link.sv
module swl_link
  import swl_pkg::*;
#(
  parameter int BIT_CYC      = 1200, // >= 3
  parameter int MAX_BITS     = 8,    // >= 2
  parameter int WAIT_PERIODS = 5,
  localparam int NB_W        = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                dir_tx_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic [MAX_BITS-1:0] tx_data_i,
  output logic                ready_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                par_err_o,
  output logic                timeout_o,
  input  logic                line_i,
  output logic                line_oe_o,
  output logic                line_do_o
);
  localparam int WAIT_CYC = WAIT_PERIODS * BIT_CYC;

  swl_state_e state_q, state_d;
  logic [NB_W-1:0] idx_q, nb_q, nb_req;
  logic hold_q, pend_q;
  logic accept, is_par;

  logic bt_clr, bt_mid, bt_last;
  logic wt_clr, wt_last, wt_mid_unused;

  logic                sh_load, sh_shift, sh_in, sh_pbit, sh_par;
  logic [MAX_BITS-1:0] sh_val, sreg, tx_aligned;

  logic fin_tx, fin_rx, fin_to, samp_par, idx_inc;

  assign nb_req = (nbits_i == '0 || nbits_i > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : nbits_i;
  assign tx_aligned = tx_data_i << (NB_W'(MAX_BITS) - nb_req);
  assign accept = start_i && (state_q == ST_IDLE);
  assign is_par = (idx_q == nb_q);

  swl_period_cnt #(.PERIOD(BIT_CYC)) u_bit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(bt_clr), .mid_o(bt_mid), .last_o(bt_last)
  );

  swl_period_cnt #(.PERIOD(WAIT_CYC)) u_wait_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(wt_clr), .mid_o(wt_mid_unused), .last_o(wt_last)
  );

  swl_shift_par #(.W(MAX_BITS)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(sh_load), .load_val_i(sh_val),
    .shift_i(sh_shift), .shift_in_i(sh_in), .par_bit_i(sh_pbit),
    .sreg_o(sreg), .par_o(sh_par)
  );

  always_comb begin
    state_d  = state_q;
    bt_clr   = 1'b0;
    wt_clr   = 1'b0;
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_shift = 1'b0;
    sh_in    = 1'b0;
    sh_pbit  = 1'b0;
    fin_tx   = 1'b0;
    fin_rx   = 1'b0;
    fin_to   = 1'b0;
    samp_par = 1'b0;
    idx_inc  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        bt_clr  = 1'b1;
        wt_clr  = 1'b1;
        sh_load = 1'b1;
        sh_val  = dir_tx_i ? tx_aligned : '0;
        state_d = dir_tx_i ? ST_SYNC_LO : ST_RX_LO;
      end
      ST_SYNC_LO: if (bt_last) state_d = ST_SYNC_HI;
      ST_SYNC_HI: begin
        bt_clr  = 1'b1;
        state_d = ST_TX_BIT;
      end
      ST_TX_BIT: if (bt_last) begin
        if (is_par) begin
          fin_tx  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          sh_shift = 1'b1;
          sh_pbit  = sreg[MAX_BITS-1];
          idx_inc  = 1'b1;
        end
      end
      ST_RX_LO: if (!line_i || wt_last) begin
        wt_clr  = 1'b1;
        state_d = ST_RX_HI;
      end
      ST_RX_HI: begin
        if (line_i) begin
          bt_clr  = 1'b1;
          state_d = ST_RX_BIT;
        end else if (wt_last) begin
          fin_to  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RX_BIT: begin
        if (bt_mid) begin
          if (is_par) samp_par = 1'b1;
          else begin
            sh_shift = 1'b1;
            sh_in    = line_i;
            sh_pbit  = line_i;
          end
        end
        if (bt_last) begin
          if (is_par) begin
            fin_rx  = 1'b1;
            state_d = ST_IDLE;
          end else idx_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      nb_q      <= '0;
      hold_q    <= 1'b0;
      pend_q    <= 1'b0;
      done_o    <= 1'b0;
      rx_data_o <= '0;
      par_err_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin_tx | fin_rx | fin_to;
      if (accept) begin
        idx_q     <= '0;
        nb_q      <= nb_req;
        hold_q    <= dir_tx_i;
        pend_q    <= 1'b0;
        rx_data_o <= '0;
        par_err_o <= 1'b0;
        timeout_o <= 1'b0;
      end
      if (idx_inc)  idx_q <= idx_q + NB_W'(1);
      if (samp_par) pend_q <= line_i ^ sh_par;
      if (fin_rx) begin
        rx_data_o <= sreg;
        par_err_o <= pend_q;
      end
      if (fin_to) timeout_o <= 1'b1;
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign line_oe_o = (state_q == ST_SYNC_LO) || (state_q == ST_SYNC_HI) ||
                     (state_q == ST_TX_BIT) || ((state_q == ST_IDLE) && hold_q);
  always_comb begin
    case (state_q)
      ST_SYNC_HI: line_do_o = 1'b1;
      ST_TX_BIT:  line_do_o = is_par ? sh_par : sreg[MAX_BITS-1];
      default:    line_do_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/swl_link_chk.sv
module swl_link_chk #(
  parameter int MAX_BITS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                dir_tx_i,
  input logic                ready_o,
  input logic                done_o,
  input logic [MAX_BITS-1:0] rx_data_o,
  input logic                par_err_o,
  input logic                timeout_o,
  input logic                line_oe_o,
  input logic                line_do_o
);
  // R1
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);
  // R1
  done_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  // R1
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  tx_sync_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && dir_tx_i) |=> (line_oe_o && !line_do_o));
  // R6
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && !dir_tx_i) |=> !line_oe_o);
  // R6
  released_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_oe_o |-> !line_do_o);
  // R11
  timeout_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!par_err_o && rx_data_o == '0));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ($stable(rx_data_o) && $stable(par_err_o) && $stable(timeout_o)));
endmodule

bind swl_link swl_link_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dir_tx_i(dir_tx_i),
  .ready_o(ready_o), .done_o(done_o), .rx_data_o(rx_data_o),
  .par_err_o(par_err_o), .timeout_o(timeout_o),
  .line_oe_o(line_oe_o), .line_do_o(line_do_o)
);

// File: tb/swl_link_bench.sv
`timescale 1ns/1ps
module swl_link_bench;
  localparam int N    = 7;
  localparam int MAXB = 8;
  localparam int WP   = 5;
  localparam int LIM  = WP * N;
  localparam int H1   = N / 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, start, dir, line_in;
  logic [3:0] nbits;
  logic [7:0] txd;
  logic       ready, done, perr, tmo, oe, dout;
  logic [7:0] rxd;

  int errs = 0;
  int checks = 0;

  swl_link #(.BIT_CYC(N), .MAX_BITS(MAXB), .WAIT_PERIODS(WP)) u_swl_link (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_tx_i(dir), .nbits_i(nbits),
    .tx_data_i(txd), .ready_o(ready), .done_o(done), .rx_data_o(rxd),
    .par_err_o(perr), .timeout_o(tmo), .line_i(line_in),
    .line_oe_o(oe), .line_do_o(dout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int clampn(input int n);
    return (n == 0 || n > MAXB) ? MAXB : n;
  endfunction

  function automatic logic xorn(input logic [7:0] d, input int nb);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  // Idle cycles: handshake quiet, line state and results held (R5, R12)
  task automatic idle_chk(input int n, input bit hold, input logic [7:0] erx,
                          input logic epe, input logic eto);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 idle ready/done", {ready, done}, 2'b10);
      chk("R5 idle line", {oe, dout}, {hold, 1'b0});
      chk("R12 idle results", {rxd, perr, tmo}, {erx, epe, eto});
    end
  endtask

  task automatic run_tx(input logic [7:0] d, input int nin, input bit poke);
    int nb = clampn(nin);
    int total = N + 1 + (nb + 1) * N;
    logic p = xorn(d, nb);
    @(negedge clk);
    txd = d; nbits = 4'(nin); dir = 1'b1; start = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= total; j++) begin
      logic edo;
      string tag;
      @(negedge clk);
      start = 1'b0;
      if (poke && j == 4) begin
        start = 1'b1; dir = 1'b0; nbits = 4'd1; txd = ~d;
      end
      if (j < N) begin edo = 1'b0; tag = "R3 sync low"; end
      else if (j == N) begin edo = 1'b1; tag = "R3 sync high"; end
      else if (j < N + 1 + nb * N) begin
        edo = d[nb - 1 - (j - N - 1) / N];
        tag = (nin == 0 || nin > MAXB) ? "R2 R4 data" : "R4 data";
      end
      else if (j < total) begin edo = p; tag = "R5 parity"; end
      else begin edo = 1'b0; tag = "R5 end low"; end
      if (poke && j > 4) tag = {"R1 busy ", tag};
      chk(tag, {oe, edo == dout, ready, done}, {1'b1, 1'b1, j == total, j == total});
      if (j == total) chk("R12 cleared by tx", {rxd, perr, tmo}, '0);
    end
    start = 1'b0;
  endtask

  // mode 0: normal frame, 1: line stays high, 2: line stuck low
  task automatic run_rx(input logic [7:0] d, input int nin, input int mode, input int lead,
                        input bit badp, input bit glitch);
    int nb = clampn(nin);
    logic p = xorn(d, nb);
    logic [7:0] mask = 8'((1 << nb) - 1);
    int e, fin;
    logic [7:0] erx;
    logic epe, eto;
    string tag;
    e = (mode == 0) ? lead + N : LIM;
    fin = (mode == 2) ? lead + 1 + LIM : e + 1 + (nb + 1) * N;
    erx = (mode == 0) ? (d & mask) : (mode == 1) ? mask : 8'h00;
    epe = (mode == 0) ? badp : (mode == 1) ? ((nb % 2) == 0) : 1'b0;
    eto = (mode == 2);
    tag = (mode == 0) ? "R8 R9 frame timing" : (mode == 1) ? "R7 window expiry" : "R11 timeout";
    @(negedge clk);
    txd = 8'h00; nbits = 4'(nin); dir = 1'b0; start = 1'b1; line_in = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= fin; j++) begin
      logic v;
      @(negedge clk);
      start = 1'b0;
      if (mode == 1) v = 1'b1;
      else if (mode == 2) v = (j < lead);
      else if (j < lead) v = 1'b1;
      else if (j < lead + N) v = 1'b0;
      else if (j == e) v = 1'b1;
      else begin
        int k = (j - e - 1) / N;
        int c = (j - e - 1) % N;
        if (k < nb) v = d[nb - 1 - k];
        else if (k == nb) v = p ^ badp;
        else v = 1'b1;
        if (glitch && k <= nb && c != H1 && (c == 0 || c == N - 1)) v = ~v;
      end
      line_in = v;
      chk("R6 released", {oe, dout}, 2'b00);
      chk(tag, {ready, done}, {j == fin, j == fin});
      if (j == fin) begin
        chk((mode == 2) ? "R11 data" : "R9 data", {24'h0, rxd}, {24'h0, erx});
        chk((mode == 2) ? "R11 parity flag" : "R10 parity flag", {31'h0, perr}, {31'h0, epe});
        chk("R11 timeout flag", {31'h0, tmo}, {31'h0, eto});
      end
    end
    line_in = 1'b1;
    idle_chk(3, 1'b0, erx, epe, eto);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dir = 1'b0; nbits = 4'd8; txd = 8'h00; line_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13
    chk("R13 reset", {ready, done, oe, dout, rxd, perr, tmo}, {1'b1, 3'b000, 8'h00, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 after release", {ready, done, oe, dout, rxd, perr, tmo}, {1'b1, 3'b000, 8'h00, 2'b00});

    run_tx(8'hA5, 8, 1'b0);
    idle_chk(3, 1'b1, 8'h00, 1'b0, 1'b0);
    run_rx(8'h3C, 8, 0, 4, 1'b0, 1'b0);
    run_tx(8'h01, 1, 1'b1);
    idle_chk(2, 1'b1, 8'h00, 1'b0, 1'b0);
    run_tx(8'h13, 5, 1'b0);
    run_tx(8'hC6, 0, 1'b0);
    run_tx(8'h5A, 12, 1'b0);
    run_rx(8'h2D, 6, 0, 0, 1'b1, 1'b1);
    run_rx(8'h0B, 4, 0, 10, 1'b0, 1'b1);
    run_rx(8'hFF, 1, 0, 2, 1'b1, 1'b0);
    run_rx(8'h00, 8, 1, 0, 1'b0, 1'b0);
    run_rx(8'h00, 3, 1, 0, 1'b0, 1'b0);
    run_rx(8'h00, 8, 2, 2, 1'b0, 1'b0);
    run_rx(8'h81, 0, 0, 0, 1'b0, 1'b1);
    finish_run();
  end
endmodule